// File: doc/BRIEF.md
# Time-Multiplexed FIR Filter

This block filters a stream of signed 8-bit samples with a finite impulse response of `TAPS` taps. A single multiplier and adder serve every tap in turn. When a sample is accepted, it is written into a circular history memory, and the oldest entry in that memory is overwritten. A sequencer then steps through the taps, one per clock. For each tap it reads one stored sample and its fixed coefficient, and it feeds the product into the accumulator.

The upstream side offers a sample by raising `in_valid`. The sample is taken on a clock edge at which `in_ready` is high. `out_valid` marks the single cycle in which `out_sum` holds the finished result. After that cycle the block can take the next sample. At most one sample enters every `TAPS+2` cycles.

Top module: `fir_seq`

## Requirements
- R1: When sample x[n] is accepted, the result is y[n] = sum over k = 0..TAPS-1 of c[k]·x[n-k]. Here x[n] is the newest accepted sample and x[n-k] is the sample accepted k acceptances earlier.
- R2: History entries that have not yet been written since reset read as zero.
- R3: The result is a signed value `8+8+clog2(TAPS)` bits wide. It never wraps, including for all-extreme inputs (-128 and 127).
- R4: `in_ready` is high in the idle state. It goes low on the edge after an acceptance and stays low for `TAPS+1` cycles.
- R5: A sample presented while `in_ready` is low is ignored. It does not enter the history and it does not start a computation.
- R6: For an acceptance at clock edge e, `out_valid` is high for exactly one cycle, the cycle that follows edge e+TAPS+1. `out_sum` carries the result in that cycle.
- R7: After synchronous active-high reset, `in_ready` is 1 and `out_valid` is 0. The history is all zero.
- R8: Coefficient k is the signed 8-bit value ((29·k + 5) mod 256) − 128. With the default `TAPS`=8, a unit impulse therefore reproduces these values in tap order.
- R9: After more than `TAPS` acceptances, the oldest sample no longer contributes. The history keeps exactly the last `TAPS` samples.
- R10: A sample held valid through the result cycle is accepted in that same cycle, because `in_ready` is high there. This gives back-to-back operation at one sample per `TAPS+2` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered |
| in_sample | input | 8 | Signed input sample |
| in_ready | output | 1 | The block can take a sample this cycle |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | 8+8+clog2(TAPS) | Signed filter result, meaningful while out_valid is high |

## Verification
The assertions assume that `in_valid` and `in_sample` change only between edges and are never X. They also assume that reset is held for at least one edge before traffic starts. The latency and busy-window checks track acceptances as the `in_valid && in_ready` handshake. Because of this, the assertions stay valid however the stimulus behaves while the block is busy.

The stimulus drives inputs only on falling edges and releases reset before the first offer. It keeps `in_valid` high through busy windows and changes the sample value while it waits, so that the ignore rule is exercised without breaking the assumptions above.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;

    localparam int SAMPLE_W = 8;
    localparam int COEF_W   = 8;
    localparam int PROD_W   = SAMPLE_W + COEF_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [PROD_W-1:0]   prod_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    // operand tag travelling alongside the registered memory reads
    typedef struct packed {
        logic vld;
        logic first;
        logic last;
    } op_tag_t;

    function automatic coef_t coef_at(input int k);
        int raw;
        raw = ((29 * k + 5) % 256) - 128;
        return coef_t'(raw);
    endfunction

endpackage

// File: rtl/fir_seq_coef_rom.sv
module fir_seq_coef_rom
    import fir_seq_pkg::*;
#(
    parameter int TAPS = 8,
    localparam int AW = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    output coef_t         q
);
    coef_t tbl [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_tbl
        assign tbl[i] = coef_at(i);
    end

    always_ff @(posedge clk) begin
        q <= tbl[addr];
    end
endmodule

// File: rtl/fir_seq_hist_ram.sv
module fir_seq_hist_ram
    import fir_seq_pkg::*;
#(
    parameter int TAPS = 8,
    localparam int AW = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sample_t       wdata,
    input  logic [AW-1:0] raddr,
    output sample_t       q
);
    sample_t mem [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) mem[i] <= '0;
            q <= '0;
        end else begin
            if (we) mem[waddr] <= wdata;
            q <= mem[raddr];
        end
    end
endmodule

// File: rtl/fir_seq_ctrl.sv
module fir_seq_ctrl
    import fir_seq_pkg::*;
#(
    parameter int TAPS = 8,
    localparam int AW = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] tap_addr,
    output op_tag_t       op_tag
);
    localparam logic [AW-1:0] LAST   = AW'(TAPS - 1);
    localparam logic [AW:0]   TAPS_X = (AW+1)'(TAPS);

    seq_state_e    state;
    logic [AW-1:0] tap;
    logic [AW-1:0] wptr;
    logic [AW-1:0] newest;
    logic          accept;
    logic          issue;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign issue    = (state == ST_RUN);
    assign wr_en    = accept;
    assign wr_addr  = wptr;
    assign tap_addr = tap;

    // history slot of tap k: newest minus k, modulo TAPS
    always_comb begin
        if (newest >= tap) rd_addr = newest - tap;
        else               rd_addr = AW'({1'b0, newest} + TAPS_X - {1'b0, tap});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            tap    <= '0;
            wptr   <= '0;
            newest <= '0;
            op_tag <= '0;
        end else begin
            op_tag.vld   <= issue;
            op_tag.first <= issue && (tap == '0);
            op_tag.last  <= issue && (tap == LAST);
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        newest <= wptr;
                        wptr   <= (wptr == LAST) ? '0 : wptr + 1'b1;
                        tap    <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tap == LAST) begin
                        state <= ST_DRAIN;
                    end else begin
                        tap <= tap + 1'b1;
                    end
                end
                ST_DRAIN: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fir_seq_mac.sv
module fir_seq_mac
    import fir_seq_pkg::*;
#(
    parameter int ACC_W = 19
) (
    input  logic                    clk,
    input  logic                    rst,
    input  op_tag_t                 tag,
    input  sample_t                 a,
    input  coef_t                   b,
    output logic signed [ACC_W-1:0] acc,
    output logic                    done
);
    prod_t                   prod;
    logic signed [ACC_W-1:0] prod_x;

    assign prod   = a * b;
    assign prod_x = ACC_W'(prod);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            done <= 1'b0;
        end else begin
            done <= tag.vld && tag.last;
            if (tag.vld) begin
                acc <= tag.first ? prod_x : acc + prod_x;
            end
        end
    end
endmodule

// File: rtl/fir_seq.sv
module fir_seq
    import fir_seq_pkg::*;
#(
    parameter int TAPS = 8,
    localparam int AW    = $clog2(TAPS),
    localparam int ACC_W = SAMPLE_W + COEF_W + $clog2(TAPS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [7:0]       in_sample,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_sum
);
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] tap_addr;
    op_tag_t       op_tag;
    sample_t       hist_q;
    coef_t         coef_q;

    fir_seq_ctrl #(.TAPS(TAPS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .tap_addr (tap_addr),
        .op_tag   (op_tag)
    );

    fir_seq_hist_ram #(.TAPS(TAPS)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (in_sample),
        .raddr (rd_addr),
        .q     (hist_q)
    );

    fir_seq_coef_rom #(.TAPS(TAPS)) u_rom (
        .clk  (clk),
        .addr (tap_addr),
        .q    (coef_q)
    );

    fir_seq_mac #(.ACC_W(ACC_W)) u_mac (
        .clk  (clk),
        .rst  (rst),
        .tag  (op_tag),
        .a    (hist_q),
        .b    (coef_q),
        .acc  (out_sum),
        .done (out_valid)
    );
endmodule

// File: rtl/fir_seq_chk.sv
module fir_seq_chk #(
    parameter int TAPS  = 8,
    parameter int ACC_W = 19
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic signed [ACC_W-1:0] out_sum
);
    localparam int BOUND = TAPS * 128 * 128;

    int  since;
    logic acc_hs;
    assign acc_hs = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst)                  since <= -1;
        else if (acc_hs)          since <= 0;
        else if (since >= 0 && since <= TAPS + 1) since <= since + 1;
    end

    // R6: a result strobe is exactly TAPS+1 edges after its acceptance
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (since == TAPS + 1));

    // R6: strobe lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4: busy window keeps ready low
    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (since >= 0 && since <= TAPS) |-> !in_ready);

    // R4: ready drops right after an acceptance
    a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
        acc_hs |=> !in_ready);

    // R10: the result cycle is also a ready cycle
    a_r10_ready_at_result: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    // R3: result stays within the representable bound
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_sum) <= BOUND && int'(out_sum) >= -BOUND));
endmodule

bind fir_seq fir_seq_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/fir_seq_bench.sv
module fir_seq_bench;
    localparam int N     = 8;
    localparam int ACC_W = 16 + $clog2(N);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    in_valid = 1'b0;
    logic signed [7:0]       in_sample = '0;
    logic                    in_ready;
    logic                    out_valid;
    logic signed [ACC_W-1:0] out_sum;

    always #10 clk = ~clk;

    fir_seq #(.TAPS(N)) u_fir_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    string req = "R7";

    // reference model state
    int hist[$];
    int busy = 0;
    int pend = -1;
    int exp_sum = 0;
    int n_acc = 0;
    int lcg = 12345;

    function automatic int coef(input int k);
        return ((29 * k + 5) % 256) - 128;
    endfunction

    task automatic check(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, compare, then advance model at rising edge
    task automatic step(input bit v, input int x);
        bit acc;
        @(negedge clk);
        in_valid  = v;
        in_sample = 8'(x);
        check("R4", "in_ready", int'(in_ready), int'(busy == 0));
        check("R6", "out_valid", int'(out_valid), int'(pend == 0));
        if (pend == 0) check(req, "out_sum", int'(out_sum), exp_sum);
        acc = v && (busy == 0);
        @(posedge clk);
        if (busy > 0) busy--;
        if (pend > 0) pend--;
        else if (pend == 0) pend = -1;
        if (acc) begin
            hist.push_front(x);
            void'(hist.pop_back());
            exp_sum = 0;
            for (int k = 0; k < N; k++) exp_sum += hist[k] * coef(k);
            busy = N + 1;
            pend = N + 1;
            n_acc++;
        end
    endtask

    task automatic offer(input int x);
        step(1'b1, x);
        while (busy > 0) step(1'b1, (x * 7 + 3) % 100);  // R5: ignored while busy
    endtask

    function automatic int rnd();
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return ((lcg >> 8) % 256) - 128;
    endfunction

    initial begin
        for (int i = 0; i < N; i++) hist.push_back(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        req = "R7";
        check("R7", "reset in_ready", int'(in_ready), 1);
        check("R7", "reset out_valid", int'(out_valid), 0);
        check("R7", "reset out_sum", int'(out_sum), 0);

        // R8/R2: unit impulse, output walks the coefficients, unwritten history is zero
        req = "R8";
        offer(1);
        for (int i = 1; i < N; i++) offer(0);
        repeat (N + 3) step(1'b0, 0);

        // R1: ramp with gaps between offers
        req = "R1";
        for (int i = 0; i < N + 2; i++) begin
            offer(i * 9 - 40);
            repeat (i % 3) step(1'b0, 0);
        end
        repeat (N + 3) step(1'b0, 0);

        // R3: extremes
        req = "R3";
        for (int i = 0; i < N; i++) offer(-128);
        for (int i = 0; i < N; i++) offer(((i % 2) == 0) ? 127 : -128);
        repeat (N + 3) step(1'b0, 0);

        // R9/R10/R5: continuous valid with changing data, wraps history many times
        req = "R9";
        for (int i = 0; i < 6 * N * (N + 2); i++) step(1'b1, rnd());
        repeat (N + 3) step(1'b0, 0);
        req = "R10";
        check("R10", "acceptances counted", int'(n_acc > 9 * N), 1);
        repeat (4 * N * (N + 2)) step(1'b1, rnd());
        repeat (N + 3) step(1'b0, 0);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule